// File: doc/BRIEF.md
# Pipelined Byte-Lane Dual-Port RAM

This block is a synchronous memory with two independent ports, left and right. Each port has its own clock and reset, and either port can read or write any word while the other port is active, including the same word. Every control, address and data input is captured on the rising edge of that port's clock. Read data leaves a one-stage output register, so it appears one clock after the address is captured. A word is 18 bits wide and is split into two 9-bit lanes, and each lane has its own active-low enable.

The address for each port comes from a per-port burst counter. The counter can be cleared, loaded from the address pins, advanced by one, or held. Output drive follows the data through the same pipeline stage. Each lane's drive is reported on a drive-enable bit instead of a tristate pin. An asynchronous output-enable input can remove that drive at any time.

The port is selected when its active-low select is low and its active-high select is high. This lets banks be stacked in depth without outside decoding. After any deselect, the outputs stay undriven until the port has been selected on two clock edges in a row.

Top module: `dpr_top`

## Requirements
- R1: A word is 18 bits. Lane 1 is bits 17..9 and is enabled by laneEnN bit 1 low. Lane 0 is bits 8..0 and is enabled by laneEnN bit 0 low. A write changes only the enabled lanes, and a read drives only the enabled lanes.
- R2: A port is selected only on an edge where csLoN is 0 and csHi is 1. On any other edge, that port writes nothing, and the read it would have made is never driven.
- R3: On a selected edge, rdWr = 1 makes a read and rdWr = 0 makes a write.
- R4: An access captured at edge k loads dout and the per-lane drive bits at edge k+1. A write captured at edge k commits to the array at edge k+1. A later read on either port returns the new data.
- R5: While oeN is 1, both drive bits are 0 at once, whatever the pipeline holds.
- R6: A read drives its lanes only if its edge and the edge just before it were both selected. With the default REACT_CYC = 2, this means two consecutive selected edges.
- R7: The address used at an edge is chosen in this priority order: 0 if zeroN is 0; otherwise addr if loadN is 0; otherwise counter + 1 if stepN is 0; otherwise the counter value. The counter keeps the chosen value. It updates whether or not the port is selected.
- R8: Counting up from the highest address wraps to address 0.
- R9: When no read is captured at an edge, dout keeps its value on the next edge and the drive bits go to 0.
- R10: A read whose array access happens on the same edge as the other port's write commit returns the old contents. A read on a later edge returns the new contents.
- R11: While a port's reset is low, that port's dout, drive bits, counter and selection streak are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkL | input | 1 | Left port clock |
| rstNL | input | 1 | Left port asynchronous reset, active low |
| csLoNL | input | 1 | Left select, active low |
| csHiL | input | 1 | Left select, active high |
| rdWrL | input | 1 | Left direction: 1 read, 0 write |
| laneEnNL | input | 2 | Left lane enables, active low (bit 1 = upper lane) |
| oeNL | input | 1 | Left asynchronous output enable, active low |
| zeroNL | input | 1 | Left counter clear, active low |
| loadNL | input | 1 | Left external address load, active low |
| stepNL | input | 1 | Left counter advance, active low |
| addrL | input | ADDR_W | Left external address |
| dinL | input | 18 | Left write data |
| doutL | output | 18 | Left read data register |
| driveL | output | 2 | Left per-lane output drive enables |
| clkR | input | 1 | Right port clock |
| rstNR | input | 1 | Right port asynchronous reset, active low |
| csLoNR | input | 1 | Right select, active low |
| csHiR | input | 1 | Right select, active high |
| rdWrR | input | 1 | Right direction: 1 read, 0 write |
| laneEnNR | input | 2 | Right lane enables, active low (bit 1 = upper lane) |
| oeNR | input | 1 | Right asynchronous output enable, active low |
| zeroNR | input | 1 | Right counter clear, active low |
| loadNR | input | 1 | Right external address load, active low |
| stepNR | input | 1 | Right counter advance, active low |
| addrR | input | ADDR_W | Right external address |
| dinR | input | 18 | Right write data |
| doutR | output | 18 | Right read data register |
| driveR | output | 2 | Right per-lane output drive enables |

## Verification
The bench attacks the first reads after a deselect. A design that drives these too early shows drive bits one cycle ahead of the model. The bench also runs one port's reads against the other port's writes on the same edge, where a design that forwards the new data, or one that loses a commit, returns the wrong word. Partial-lane writes and clear-versus-load priority catch a design that merges lanes or orders the address sources wrongly. Counter wrap catches one that carries into a missing bit. Held reads and write cycles expose a data register that reloads when it should hold, or a drive that lingers after the read has ended.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  // Strobes from a port's control stage to the shared datapath
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    logic             drvArm;
    logic [LANES-1:0] laneOn;
  } portReq_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int REACT_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLoN,
  input  logic              csHi,
  input  logic              rdWr,
  input  logic [LANES-1:0]  laneEnN,
  input  logic              zeroN,
  input  logic              loadN,
  input  logic              stepN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [WORD_W-1:0] din,
  output logic [ADDR_W-1:0] accAddr,
  output portReq_t          req,
  output logic [WORD_W-1:0] wrData
);
  localparam int STREAK_W = $clog2(REACT_CYC + 1);
  localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(REACT_CYC);

  logic                selNow;
  logic [ADDR_W-1:0]   cntQ;
  logic [ADDR_W-1:0]   addrNext;
  logic [STREAK_W-1:0] streakQ;
  logic [STREAK_W-1:0] streakNext;
  portReq_t            reqQ;
  logic [WORD_W-1:0]   dataQ;

  // Address source priority: clear, load, advance, hold (R7)
  always_comb begin
    selNow = !csLoN && csHi;
    if (!zeroN)       addrNext = '0;
    else if (!loadN)  addrNext = extAddr;
    else if (!stepN)  addrNext = cntQ + 1'b1;
    else              addrNext = cntQ;
    if (!selNow)                   streakNext = '0;
    else if (streakQ == STREAK_MAX) streakNext = STREAK_MAX;
    else                           streakNext = streakQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      streakQ <= '0;
      reqQ    <= '0;
      dataQ   <= '0;
    end else begin
      cntQ        <= addrNext;
      streakQ     <= streakNext;
      reqQ.wrStb  <= selNow && !rdWr;
      reqQ.rdStb  <= selNow && rdWr;
      reqQ.drvArm <= selNow && rdWr && (streakNext == STREAK_MAX);
      reqQ.laneOn <= ~laneEnN;
      dataQ       <= din;
    end
  end

  assign accAddr = cntQ;
  assign req     = reqQ;
  assign wrData  = dataQ;
endmodule

// File: rtl/dpr_core.sv
module dpr_core
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clkL,
  input  logic              rstNL,
  input  portReq_t          reqL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [WORD_W-1:0] wdL,
  output logic [WORD_W-1:0] rdL,
  output logic [LANES-1:0]  drvL,
  input  logic              clkR,
  input  logic              rstNR,
  input  portReq_t          reqR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [WORD_W-1:0] wdR,
  output logic [WORD_W-1:0] rdR,
  output logic [LANES-1:0]  drvR
);
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writer; per-lane tags mark which bank is newest
  logic [WORD_W-1:0] bankL [DEPTH];
  logic [WORD_W-1:0] bankR [DEPTH];
  logic [LANES-1:0]  tagL  [DEPTH];
  logic [LANES-1:0]  tagR  [DEPTH];

  // Left commit: equal tags mean left is newest
  always_ff @(posedge clkL) begin
    if (reqL.wrStb) begin
      for (int b = 0; b < LANES; b++) begin
        if (reqL.laneOn[b]) begin
          bankL[addrL][b*LANE_W +: LANE_W] <= wdL[b*LANE_W +: LANE_W];
          tagL[addrL][b]                   <= tagR[addrL][b];
        end
      end
    end
  end

  // Right commit: unequal tags mean right is newest
  always_ff @(posedge clkR) begin
    if (reqR.wrStb) begin
      for (int b = 0; b < LANES; b++) begin
        if (reqR.laneOn[b]) begin
          bankR[addrR][b*LANE_W +: LANE_W] <= wdR[b*LANE_W +: LANE_W];
          tagR[addrR][b]                   <= ~tagL[addrR][b];
        end
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : gPort
    logic              pClk;
    logic              pRstN;
    portReq_t          pReq;
    logic [ADDR_W-1:0] pAddr;
    logic [WORD_W-1:0] curWord;
    logic [WORD_W-1:0] q;
    logic [LANES-1:0]  drv;

    assign pClk  = (p == 0) ? clkL  : clkR;
    assign pRstN = (p == 0) ? rstNL : rstNR;
    assign pReq  = (p == 0) ? reqL  : reqR;
    assign pAddr = (p == 0) ? addrL : addrR;

    always_comb begin
      for (int b = 0; b < LANES; b++) begin
        curWord[b*LANE_W +: LANE_W] = (tagL[pAddr][b] == tagR[pAddr][b])
                                    ? bankL[pAddr][b*LANE_W +: LANE_W]
                                    : bankR[pAddr][b*LANE_W +: LANE_W];
      end
    end

    // Output stage: data and drive advance together
    always_ff @(posedge pClk or negedge pRstN) begin
      if (!pRstN) begin
        q   <= '0;
        drv <= '0;
      end else if (pReq.rdStb) begin
        q   <= curWord;
        drv <= pReq.drvArm ? pReq.laneOn : '0;
      end else begin
        drv <= '0;
      end
    end
  end

  assign rdL  = gPort[0].q;
  assign drvL = gPort[0].drv;
  assign rdR  = gPort[1].q;
  assign drvR = gPort[1].drv;
endmodule

// File: rtl/dpr_top.sv
module dpr_top
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int REACT_CYC = 2
) (
  input  logic              clkL,
  input  logic              rstNL,
  input  logic              csLoNL,
  input  logic              csHiL,
  input  logic              rdWrL,
  input  logic [1:0]        laneEnNL,
  input  logic              oeNL,
  input  logic              zeroNL,
  input  logic              loadNL,
  input  logic              stepNL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [17:0]       dinL,
  output logic [17:0]       doutL,
  output logic [1:0]        driveL,
  input  logic              clkR,
  input  logic              rstNR,
  input  logic              csLoNR,
  input  logic              csHiR,
  input  logic              rdWrR,
  input  logic [1:0]        laneEnNR,
  input  logic              oeNR,
  input  logic              zeroNR,
  input  logic              loadNR,
  input  logic              stepNR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [17:0]       dinR,
  output logic [17:0]       doutR,
  output logic [1:0]        driveR
);
  portReq_t          reqL, reqR;
  logic [ADDR_W-1:0] accAddrL, accAddrR;
  logic [WORD_W-1:0] wrDataL, wrDataR;
  logic [LANES-1:0]  drvRawL, drvRawR;

  dpr_port_ctrl #(.ADDR_W(ADDR_W), .REACT_CYC(REACT_CYC)) uCtrlL (
    .clk(clkL), .rstN(rstNL), .csLoN(csLoNL), .csHi(csHiL), .rdWr(rdWrL),
    .laneEnN(laneEnNL), .zeroN(zeroNL), .loadN(loadNL), .stepN(stepNL),
    .extAddr(addrL), .din(dinL), .accAddr(accAddrL), .req(reqL), .wrData(wrDataL)
  );

  dpr_port_ctrl #(.ADDR_W(ADDR_W), .REACT_CYC(REACT_CYC)) uCtrlR (
    .clk(clkR), .rstN(rstNR), .csLoN(csLoNR), .csHi(csHiR), .rdWr(rdWrR),
    .laneEnN(laneEnNR), .zeroN(zeroNR), .loadN(loadNR), .stepN(stepNR),
    .extAddr(addrR), .din(dinR), .accAddr(accAddrR), .req(reqR), .wrData(wrDataR)
  );

  dpr_core #(.ADDR_W(ADDR_W)) uCore (
    .clkL(clkL), .rstNL(rstNL), .reqL(reqL), .addrL(accAddrL), .wdL(wrDataL),
    .rdL(doutL), .drvL(drvRawL),
    .clkR(clkR), .rstNR(rstNR), .reqR(reqR), .addrR(accAddrR), .wdR(wrDataR),
    .rdR(doutR), .drvR(drvRawR)
  );

  // Asynchronous output enable overrides the registered drive (R5)
  assign driveL = drvRawL & {LANES{~oeNL}};
  assign driveR = drvRawR & {LANES{~oeNR}};
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clkL,
  input logic              rstNL,
  input logic              csLoNL,
  input logic              csHiL,
  input logic              rdWrL,
  input logic [1:0]        laneEnNL,
  input logic              oeNL,
  input logic              zeroNL,
  input logic              loadNL,
  input logic              stepNL,
  input logic [ADDR_W-1:0] addrL,
  input logic [17:0]       doutL,
  input logic [1:0]        driveL,
  input logic [ADDR_W-1:0] accAddrL,
  input logic              rdStbL,
  input logic              clkR,
  input logic              rstNR,
  input logic              csLoNR,
  input logic              csHiR,
  input logic              rdWrR,
  input logic              oeNR,
  input logic [1:0]        driveR
);
  a_r5_oe_blocks_left: assert property (@(posedge clkL) disable iff (!rstNL)
    oeNL |-> driveL == 2'b00);

  a_r5_oe_blocks_right: assert property (@(posedge clkR) disable iff (!rstNR)
    oeNR |-> driveR == 2'b00);

  a_r2_drive_needs_read_left: assert property (@(posedge clkL) disable iff (!rstNL)
    (driveL != 2'b00) |-> $past(!csLoNL && csHiL && rdWrL, 2));

  a_r2_drive_needs_read_right: assert property (@(posedge clkR) disable iff (!rstNR)
    (driveR != 2'b00) |-> $past(!csLoNR && csHiR && rdWrR, 2));

  a_r1_upper_lane: assert property (@(posedge clkL) disable iff (!rstNL)
    driveL[1] |-> !$past(laneEnNL[1], 2));

  a_r1_lower_lane: assert property (@(posedge clkL) disable iff (!rstNL)
    driveL[0] |-> !$past(laneEnNL[0], 2));

  a_r7_clear_wins: assert property (@(posedge clkL) disable iff (!rstNL)
    !zeroNL |=> accAddrL == '0);

  a_r7_load: assert property (@(posedge clkL) disable iff (!rstNL)
    (zeroNL && !loadNL) |=> accAddrL == $past(addrL));

  a_r7_hold: assert property (@(posedge clkL) disable iff (!rstNL)
    (zeroNL && loadNL && stepNL) |=> $stable(accAddrL));

  a_r9_data_holds: assert property (@(posedge clkL) disable iff (!rstNL)
    !$past(rdStbL) |-> $stable(doutL));
endmodule

bind dpr_top dpr_checker #(.ADDR_W(ADDR_W)) uChk (
  .clkL(clkL), .rstNL(rstNL), .csLoNL(csLoNL), .csHiL(csHiL), .rdWrL(rdWrL),
  .laneEnNL(laneEnNL), .oeNL(oeNL), .zeroNL(zeroNL), .loadNL(loadNL), .stepNL(stepNL),
  .addrL(addrL), .doutL(doutL), .driveL(driveL), .accAddrL(accAddrL),
  .rdStbL(reqL.rdStb),
  .clkR(clkR), .rstNR(rstNR), .csLoNR(csLoNR), .csHiR(csHiR), .rdWrR(rdWrR),
  .oeNR(oeNR), .driveR(driveR)
);

// File: tb/sim_dpr_top.sv
module sim_dpr_top;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        csLoN [2];
  logic        csHi  [2];
  logic        rdWr  [2];
  logic        oeN   [2];
  logic        zeroN [2];
  logic        loadN [2];
  logic        stepN [2];
  logic [1:0]  beN   [2];
  logic [AW-1:0] addr [2];
  logic [17:0] din   [2];
  logic [17:0] doutL, doutR;
  logic [1:0]  driveL, driveR;

  dpr_top #(.ADDR_W(AW)) u0 (
    .clkL(clk), .rstNL(rstN), .csLoNL(csLoN[0]), .csHiL(csHi[0]), .rdWrL(rdWr[0]),
    .laneEnNL(beN[0]), .oeNL(oeN[0]), .zeroNL(zeroN[0]), .loadNL(loadN[0]),
    .stepNL(stepN[0]), .addrL(addr[0]), .dinL(din[0]), .doutL(doutL), .driveL(driveL),
    .clkR(clk), .rstNR(rstN), .csLoNR(csLoN[1]), .csHiR(csHi[1]), .rdWrR(rdWr[1]),
    .laneEnNR(beN[1]), .oeNR(oeN[1]), .zeroNR(zeroN[1]), .loadNR(loadN[1]),
    .stepNR(stepN[1]), .addrR(addr[1]), .dinR(din[1]), .doutR(doutR), .driveR(driveR)
  );

  int    nChecks = 0;
  int    nErrors = 0;
  string tag = "R11";
  bit    done = 1'b0;

  // Behavioural reference model
  logic [17:0] mMem [DEPTH];
  int          mCnt [2];
  int          mStreak [2];
  int          mAddr [2];
  bit          mWe [2];
  bit          mRd [2];
  bit          mArm [2];
  logic [1:0]  mBe [2];
  logic [17:0] mDin [2];
  logic [17:0] mQ [2];
  logic [1:0]  mDrv [2];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        mCnt[p] = 0; mStreak[p] = 0; mAddr[p] = 0; mWe[p] = 0; mRd[p] = 0;
        mArm[p] = 0; mBe[p] = 2'b11; mDin[p] = '0; mQ[p] = '0; mDrv[p] = 2'b00;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (mRd[p]) begin
          mQ[p]   = mMem[mAddr[p]];
          mDrv[p] = mArm[p] ? ~mBe[p] : 2'b00;
        end else begin
          mDrv[p] = 2'b00;
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (mWe[p]) begin
          if (!mBe[p][0]) mMem[mAddr[p]][8:0]  = mDin[p][8:0];
          if (!mBe[p][1]) mMem[mAddr[p]][17:9] = mDin[p][17:9];
        end
      end
      for (int p = 0; p < 2; p++) begin
        bit sel;
        int a;
        sel = !csLoN[p] && csHi[p];
        if (!zeroN[p])      a = 0;
        else if (!loadN[p]) a = int'(addr[p]);
        else if (!stepN[p]) a = (mCnt[p] + 1) % DEPTH;
        else                a = mCnt[p];
        mCnt[p]  = a;
        mAddr[p] = a;
        mStreak[p] = sel ? ((mStreak[p] >= 2) ? 2 : mStreak[p] + 1) : 0;
        mWe[p]   = sel && !rdWr[p];
        mRd[p]   = sel && rdWr[p];
        mArm[p]  = mRd[p] && (mStreak[p] >= 2);
        mBe[p]   = beN[p];
        mDin[p]  = din[p];
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the model once per cycle, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("doutL",  32'(doutL),  32'(mQ[0]));
      check("driveL", 32'(driveL), 32'(mDrv[0] & {2{~oeN[0]}}));
      check("doutR",  32'(doutR),  32'(mQ[1]));
      check("driveR", 32'(driveR), 32'(mDrv[1] & {2{~oeN[1]}}));
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(int p);
    csLoN[p] = 1'b1; csHi[p] = 1'b1; rdWr[p] = 1'b1; beN[p] = 2'b00;
    zeroN[p] = 1'b1; loadN[p] = 1'b1; stepN[p] = 1'b1;
  endtask

  task automatic op(int p, bit rd, logic [1:0] be, bit z, bit ld, bit st,
                    int a, logic [17:0] d);
    csLoN[p] = 1'b0; csHi[p] = 1'b1; rdWr[p] = rd; beN[p] = be;
    zeroN[p] = z; loadN[p] = ld; stepN[p] = st;
    addr[p] = AW'(a); din[p] = d;
  endtask

  function automatic logic [17:0] rnd18();
    return 18'($urandom);
  endfunction

  task automatic randomOps(int writer, int n);
    for (int i = 0; i < n; i++) begin
      for (int p = 0; p < 2; p++) begin
        csLoN[p] = ($urandom_range(0, 7) == 0);
        csHi[p]  = ($urandom_range(0, 7) != 0);
        rdWr[p]  = (p == writer) ? 1'($urandom) : 1'b1;
        beN[p]   = 2'($urandom);
        zeroN[p] = ($urandom_range(0, 15) != 0);
        loadN[p] = ($urandom_range(0, 3) != 0);
        stepN[p] = 1'($urandom);
        oeN[p]   = ($urandom_range(0, 7) == 0);
        addr[p]  = AW'($urandom);
        din[p]   = rnd18();
      end
      tick(1);
    end
    for (int p = 0; p < 2; p++) begin
      oeN[p] = 1'b0;
      idle(p);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0;
    for (int p = 0; p < 2; p++) begin
      idle(p);
      oeN[p] = 1'b0; addr[p] = '0; din[p] = '0;
    end
    tick(3);
    tag = "R11";
    check("reset doutL",  32'(doutL),  32'h0);
    check("reset driveL", 32'(driveL), 32'h0);
    check("reset doutR",  32'(doutR),  32'h0);
    check("reset driveR", 32'(driveR), 32'h0);
    rstN = 1'b1;
    tick(2);

    tag = "R7 fill by counter";
    op(0, 0, 2'b00, 1, 0, 1, 0, rnd18());
    tick(1);
    for (int i = 1; i < DEPTH; i++) begin
      op(0, 0, 2'b00, 1, 1, 0, 0, rnd18());
      tick(1);
    end

    tag = "R3 R4 burst read";
    op(0, 1, 2'b00, 1, 0, 1, 5, '0);
    tick(1);
    for (int i = 0; i < 6; i++) begin
      op(0, 1, 2'b00, 1, 1, 0, 0, '0);
      tick(1);
    end

    tag = "R1 lane writes";
    op(0, 0, 2'b10, 1, 0, 1, 10, rnd18()); tick(1);
    op(0, 0, 2'b01, 1, 0, 1, 11, rnd18()); tick(1);
    op(0, 0, 2'b11, 1, 0, 1, 12, rnd18()); tick(1);
    for (int a = 10; a < 13; a++) begin
      op(0, 1, 2'b00, 1, 0, 1, a, '0); tick(1);
    end
    op(0, 1, 2'b10, 1, 0, 1, 10, '0); tick(1);
    op(0, 1, 2'b01, 1, 0, 1, 11, '0); tick(1);
    op(0, 1, 2'b11, 1, 0, 1, 12, '0); tick(1);

    tag = "R2 deselected write";
    op(0, 0, 2'b00, 1, 0, 1, 20, rnd18()); csLoN[0] = 1'b1; tick(1);
    op(0, 0, 2'b00, 1, 0, 1, 21, rnd18()); csHi[0] = 1'b0; tick(1);
    for (int i = 0; i < 3; i++) begin
      op(0, 1, 2'b00, 1, 0, 1, 20, '0); tick(1);
      op(0, 1, 2'b00, 1, 0, 1, 21, '0); tick(1);
    end

    tag = "R6 reactivation";
    idle(0); tick(1);
    for (int i = 0; i < 4; i++) begin
      op(0, 1, 2'b00, 1, 0, 1, 30 + i, '0); tick(1);
    end
    csHi[0] = 1'b0; tick(1);
    op(0, 1, 2'b00, 1, 0, 1, 35, '0); tick(3);

    tag = "R5 async output enable";
    oeN[0] = 1'b1;
    op(0, 1, 2'b00, 1, 1, 0, 0, '0); tick(3);
    oeN[0] = 1'b0; tick(2);

    tag = "R9 hold";
    op(0, 1, 2'b00, 1, 0, 1, 40, '0); tick(1);
    op(0, 1, 2'b00, 1, 1, 1, 0, '0); tick(2);
    idle(0); tick(3);
    op(0, 0, 2'b00, 1, 0, 1, 41, rnd18()); tick(2);

    tag = "R8 wrap";
    op(0, 0, 2'b00, 1, 0, 1, DEPTH - 1, rnd18()); tick(1);
    op(0, 0, 2'b00, 1, 1, 0, 0, rnd18()); tick(1);
    op(0, 1, 2'b00, 1, 0, 1, DEPTH - 1, '0); tick(1);
    op(0, 1, 2'b00, 1, 1, 0, 0, '0); tick(1);
    op(0, 1, 2'b00, 1, 1, 0, 0, '0); tick(2);

    tag = "R7 clear priority";
    op(0, 1, 2'b00, 0, 0, 0, 77, '0); tick(1);
    op(0, 1, 2'b00, 1, 1, 0, 0, '0); tick(1);
    op(0, 1, 2'b00, 1, 1, 1, 0, '0); tick(2);
    op(0, 1, 2'b00, 1, 0, 0, 77, '0); tick(2);

    tag = "R10 cross port";
    op(0, 0, 2'b00, 1, 0, 1, 100, rnd18());
    op(1, 1, 2'b00, 1, 0, 1, 100, '0);
    tick(1);
    for (int i = 1; i < 16; i++) begin
      op(0, 0, 2'b00, 1, 1, 0, 0, rnd18());
      op(1, 1, 2'b00, 1, 1, 0, 0, '0);
      tick(1);
    end
    idle(0);
    op(1, 1, 2'b00, 1, 0, 1, 100, '0); tick(1);
    for (int i = 1; i < 16; i++) begin
      op(1, 1, 2'b00, 1, 1, 0, 0, '0); tick(1);
    end
    op(1, 0, 2'b00, 1, 0, 1, 200, rnd18());
    op(0, 1, 2'b00, 1, 0, 1, 199, '0);
    tick(1);
    for (int i = 1; i < 16; i++) begin
      op(1, 0, 2'b00, 1, 1, 0, 0, rnd18());
      op(0, 1, 2'b00, 1, 1, 0, 0, '0);
      tick(1);
    end
    idle(1);
    op(0, 1, 2'b00, 1, 0, 1, 200, '0); tick(1);
    for (int i = 1; i < 16; i++) begin
      op(0, 1, 2'b00, 1, 1, 0, 0, '0); tick(1);
    end
    idle(0); tick(2);

    tag = "R3 R4 mixed traffic left writer";
    randomOps(0, 600);
    tag = "R10 mixed traffic right writer";
    randomOps(1, 600);
    tick(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule